// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives a system reset output from three causes: the initial power-up, a drop of the supply below its trip level, and an expired watchdog. The supply state comes from an external comparator as a digital "supply good" level. A host keeps the watchdog alive by pulling the shared chip-select line from high to low often enough. All durations are counted in ticks of a prescaled timebase, normally one millisecond, so the same logic can run with short values in simulation.

After any cause, reset stays active until the supply has been good for a fixed hold period. The watchdog period is chosen by a 2-bit code held in a status register, and one code value turns the watchdog off. When the watchdog expires, the block emits a single-cycle event pulse. A status flag elsewhere can use it to tell a watchdog reset from a supply reset. A parameter sets the polarity of the reset output.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `pwr_on_n` is low, and after it rises, reset is active. Reset does not release while `supply_good` stays low, however many ticks arrive.
- R2: Reset releases on the HOLD_TICKS-th tick counted while the synchronized `supply_good` is continuously high. It is still active after HOLD_TICKS-1 such ticks.
- R3: A low level on `supply_good` makes reset active. This holds for a one-cycle glitch during a hold period, and it restarts the hold count from zero.
- R4: The watchdog count restarts only on a high-to-low transition of `cs_wdi`. A steady low level, a rising edge or a steady high level leaves the count running.
- R5: With the watchdog enabled, a timeout fires on the N-th tick after the last restart. N is LONG_TICKS for code 2'b00, MID_TICKS for 2'b01 and SHORT_TICKS for 2'b10.
- R6: Code 2'b11 disables the watchdog. No timeout and no event occur, however many ticks arrive.
- R7: A timeout raises `wd_event` for exactly one clock cycle. Reset becomes active on the next cycle and is then held for HOLD_TICKS ticks. After that the watchdog counts again from zero.
- R8: The watchdog count is held at zero while reset is active, so no event occurs during a reset pulse.
- R9: A change of the period code restarts the watchdog count under the new period.
- R10: With RST_ACTIVE_HIGH = 0 the output `rst_out` is low when reset is active. With RST_ACTIVE_HIGH = 1 it is high when reset is active.
- R11: `supply_good` and `cs_wdi` each pass through two flip-flops. A supply drop driven between clock edges shows on `rst_out` after the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_on_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | One-cycle timebase pulse (nominally 1 ms) |
| supply_good | input | 1 | Comparator output: 1 when the supply is above the trip level |
| cs_wdi | input | 1 | Shared chip-select / watchdog input; a falling edge restarts the watchdog |
| wd_code | input | 2 | Watchdog period code: 00 long, 01 mid, 10 short, 11 off |
| rst_out | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |
| wd_event | output | 1 | One-cycle pulse when a watchdog timeout fires |

## Verification
The bound checker watches, on every cycle, the single-cycle shape of the event pulse and the reset that follows it. It also checks that no event comes out of a reset state or under the disabled code, that a supply drop forces reset three edges later, and that a release always follows good supply. Only the directed scenarios can show the exact tick counts of the hold and of each watchdog period. The same holds for the restart rules tied to the edge direction of the chip-select line and to a change of the period code, and for the effect of the polarity parameter on the output pin.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_e;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             pwr_on_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] safe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.safe = st_q.meta;
    end

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            st_q <= '{meta: RST_VAL, safe: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.safe;
endmodule

// File: rtl/sup_hold_ctrl.sv
module sup_hold_ctrl #(
    parameter int HOLD_TICKS = 200,
    localparam int HOLD_W    = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic pwr_on_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic trip,
    output logic in_reset
);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

    typedef struct packed {
        logic              active;
        logic [HOLD_W-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok || trip) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt >= HOLD_LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_reset = st_q.active;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_rst_pkg::*;
#(
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200,
    localparam int MAX_TICKS  = (LONG_TICKS > MID_TICKS)
                                ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                                : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS),
    localparam int CNT_W      = $clog2(MAX_TICKS + 1)
) (
    input  logic       clk,
    input  logic       pwr_on_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       hold_off,
    input  logic [1:0] code,
    output logic       expire
);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(MID_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wd_code_e         code;
        logic             expire;
    } wd_t;

    wd_t              st_d, st_q;
    wd_code_e         code_e;
    logic [CNT_W-1:0] last;

    assign code_e = wd_code_e'(code);

    always_comb begin
        case (code_e)
            WD_LONG:  last = LAST_LONG;
            WD_MID:   last = LAST_MID;
            WD_SHORT: last = LAST_SHORT;
            default:  last = LAST_LONG;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        st_d.code   = code_e;
        if (hold_off || kick || (code_e == WD_OFF) || (code_e != st_q.code)) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= last) begin
                st_d.cnt    = '0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            st_q <= '{cnt: '0, code: WD_OFF, expire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = st_q.expire;
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int HOLD_TICKS      = 200,
    parameter int LONG_TICKS      = 1400,
    parameter int MID_TICKS       = 600,
    parameter int SHORT_TICKS     = 200,
    parameter bit RST_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       pwr_on_n,
    input  logic       tick,
    input  logic       supply_good,
    input  logic       cs_wdi,
    input  logic [1:0] wd_code,
    output logic       rst_out,
    output logic       wd_event
);
    localparam int SYNC_W = 2;

    typedef struct packed {
        logic cs_prev;
    } edge_t;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              supply_s, cs_s, kick;
    logic              in_reset_q, expire;
    edge_t             eg_d, eg_q;

    assign raw_in = {supply_good, cs_wdi};

    sup_sync2 #(
        .WIDTH   (SYNC_W),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .din      (raw_in),
        .dout     (sync_out)
    );

    assign supply_s = sync_out[1];
    assign cs_s     = sync_out[0];

    always_comb begin
        eg_d         = eg_q;
        eg_d.cs_prev = cs_s;
    end

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            eg_q <= '{cs_prev: 1'b1};
        end else begin
            eg_q <= eg_d;
        end
    end

    assign kick = eg_q.cs_prev & ~cs_s;

    sup_wdog #(
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wdog (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .tick     (tick),
        .kick     (kick),
        .hold_off (in_reset_q),
        .code     (wd_code),
        .expire   (expire)
    );

    sup_hold_ctrl #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_hold (
        .clk       (clk),
        .pwr_on_n  (pwr_on_n),
        .tick      (tick),
        .supply_ok (supply_s),
        .trip      (expire),
        .in_reset  (in_reset_q)
    );

    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = in_reset_q;
        end else begin : g_pol_low
            assign rst_out = ~in_reset_q;
        end
    endgenerate

    assign wd_event = expire;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
    input logic       clk,
    input logic       pwr_on_n,
    input logic       supply_good,
    input logic [1:0] wd_code,
    input logic       wd_event,
    input logic       in_reset
);
    AST_RESET_AT_POWER_ON: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $rose(pwr_on_n) |-> in_reset); // R1

    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $fell(in_reset) |-> $past(supply_good, 3)); // R2

    AST_BROWNOUT_FORCES_RESET: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $past(!supply_good, 3) |-> in_reset); // R3

    AST_DISABLED_NO_EVENT: assert property (@(posedge clk) disable iff (!pwr_on_n)
        wd_event |-> ($past(wd_code) != 2'b11)); // R6

    AST_EVENT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!pwr_on_n)
        wd_event |=> !wd_event); // R7

    AST_EVENT_THEN_RESET: assert property (@(posedge clk) disable iff (!pwr_on_n)
        wd_event |=> in_reset); // R7

    AST_NO_EVENT_IN_RESET: assert property (@(posedge clk) disable iff (!pwr_on_n)
        wd_event |-> !$past(in_reset)); // R8
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk u_chk (
    .clk         (clk),
    .pwr_on_n    (pwr_on_n),
    .supply_good (supply_good),
    .wd_code     (wd_code),
    .wd_event    (wd_event),
    .in_reset    (in_reset_q)
);

// File: tb/sup_reset_ctrl_bench.sv
`timescale 1ns/1ps
module sup_reset_ctrl_bench;
    localparam int HOLD  = 4;
    localparam int LONG  = 14;
    localparam int MID   = 6;
    localparam int SHORT = 3;

    logic       clk = 1'b0;
    logic       pwr_on_n = 1'b0;
    logic       tick = 1'b0;
    logic       supply_good = 1'b0;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_code = 2'b10;
    logic       rst_out, wd_event, rst_hi, wd_event_hi;

    int checks = 0;
    int fails  = 0;
    int events = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sup_reset_ctrl #(.HOLD_TICKS(HOLD), .LONG_TICKS(LONG), .MID_TICKS(MID),
                     .SHORT_TICKS(SHORT), .RST_ACTIVE_HIGH(1'b0)) u_sup_reset_ctrl (
        .clk(clk), .pwr_on_n(pwr_on_n), .tick(tick), .supply_good(supply_good),
        .cs_wdi(cs_wdi), .wd_code(wd_code), .rst_out(rst_out), .wd_event(wd_event));

    sup_reset_ctrl #(.HOLD_TICKS(HOLD), .LONG_TICKS(LONG), .MID_TICKS(MID),
                     .SHORT_TICKS(SHORT), .RST_ACTIVE_HIGH(1'b1)) u_alt (
        .clk(clk), .pwr_on_n(pwr_on_n), .tick(tick), .supply_good(supply_good),
        .cs_wdi(cs_wdi), .wd_code(wd_code), .rst_out(rst_hi), .wd_event(wd_event_hi));

    always @(negedge clk) if (wd_event) events++;

    function automatic bit in_rst();
        return rst_out == 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rst(input string req, input bit exp);
        chk(in_rst() == exp, req, in_rst(), exp);
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) one_tick();
    endtask

    task automatic kick();
        @(negedge clk) cs_wdi = 1'b1;
        repeat (3) @(negedge clk);
        cs_wdi = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // hold from a fresh start of good supply: HOLD-1 ticks active, HOLD-th releases
    task automatic expect_hold(input string req);
        ticks(HOLD - 1);
        chk_rst(req, 1'b1);
        one_tick();
        chk_rst(req, 1'b0);
    endtask

    task automatic t_power_up();
        repeat (3) @(negedge clk);
        chk_rst("R1", 1'b1);
        pwr_on_n = 1'b1;
        ticks(10);
        chk_rst("R1", 1'b1);
        chk(rst_hi == 1'b1, "R10", rst_hi, 1);
        supply_good = 1'b1;
        repeat (5) @(negedge clk);
        expect_hold("R2");
        chk(rst_hi == 1'b0, "R10", rst_hi, 0);
        chk(events == 0, "R2", events, 0);
    endtask

    // timeout on the limit-th tick, then hold, then count from zero again
    task automatic t_timeout(input logic [1:0] code, input int limit, input string req);
        int ev0;
        @(negedge clk) wd_code = code;
        repeat (3) @(negedge clk);
        ev0 = events;
        ticks(limit - 1);
        chk_rst(req, 1'b0);
        chk(events == ev0, req, events - ev0, 0);
        one_tick();
        chk_rst(req, 1'b1);
        chk(events == ev0 + 1, "R7", events - ev0, 1);
        expect_hold("R7");
        chk(events == ev0 + 1, "R8", events - ev0, 1);
        ticks(limit - 1);
        chk_rst("R7", 1'b0);
        one_tick();
        chk_rst("R7", 1'b1);
        expect_hold("R7");
    endtask

    task automatic t_kick();
        int ev0;
        @(negedge clk) wd_code = 2'b10;
        repeat (3) @(negedge clk);
        ev0 = events;
        ticks(SHORT - 1);
        kick();
        ticks(SHORT - 1);
        chk_rst("R4", 1'b0);
        chk(events == ev0, "R4", events - ev0, 0);
        one_tick();
        chk_rst("R4", 1'b1);
        expect_hold("R4");
        @(negedge clk) cs_wdi = 1'b1;
        repeat (4) @(negedge clk);
        ticks(SHORT - 1);
        chk_rst("R4", 1'b0);
        one_tick();
        chk_rst("R4", 1'b1);
        expect_hold("R4");
    endtask

    task automatic t_disabled();
        int ev0;
        @(negedge clk) wd_code = 2'b11;
        repeat (3) @(negedge clk);
        ev0 = events;
        ticks(LONG * 3);
        chk_rst("R6", 1'b0);
        chk(events == ev0, "R6", events - ev0, 0);
    endtask

    task automatic t_code_change();
        @(negedge clk) wd_code = 2'b00;
        repeat (3) @(negedge clk);
        ticks(LONG - 4);
        @(negedge clk) wd_code = 2'b10;
        repeat (3) @(negedge clk);
        ticks(SHORT - 1);
        chk_rst("R9", 1'b0);
        one_tick();
        chk_rst("R9", 1'b1);
        expect_hold("R9");
    endtask

    task automatic t_brownout();
        int ev0;
        @(negedge clk) wd_code = 2'b10;
        repeat (3) @(negedge clk);
        supply_good = 1'b0;
        repeat (2) @(negedge clk);
        chk_rst("R11", 1'b0);
        @(negedge clk);
        chk_rst("R3", 1'b1);
        chk(rst_hi == 1'b1, "R10", rst_hi, 1);
        ev0 = events;
        ticks(SHORT * 5);
        chk_rst("R3", 1'b1);
        chk(events == ev0, "R8", events - ev0, 0);
        supply_good = 1'b1;
        repeat (5) @(negedge clk);
        ticks(HOLD - 1);
        supply_good = 1'b0;
        @(negedge clk) supply_good = 1'b1;
        repeat (5) @(negedge clk);
        expect_hold("R3");
    endtask

    initial begin
        t_power_up();
        t_timeout(2'b10, SHORT, "R5");
        t_timeout(2'b01, MID, "R5");
        t_timeout(2'b00, LONG, "R5");
        t_kick();
        t_disabled();
        t_code_change();
        t_brownout();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule